// File: doc/BRIEF.md
# Serial Bus Clock Generator with Programmable Data Hold

This block turns a fast parent clock into the slow clock line of a two-wire serial bus. It also produces the two timing strobes a bit engine needs: one that says when the data line may be changed, and one that says when read data should be captured. The bus clock runs at the parent frequency divided by 2 × (divider + 1), with a 50 % duty cycle. The divider is 8 bits, so the slowest bus clock is the parent divided by 512. The bus is meant to run at 20 MHz at most, and a setting near 3 MHz is typical.

The data-change strobe is placed a programmable number of parent cycles after each falling edge of the bus clock. This number comes from a 3-bit hold field. The hold keeps the data line from moving near the edge that the far end uses. The capture strobe marks the rising edge.

Starting and stopping never produce a short clock pulse. Run enable only begins a phase from the idle-high level, and it never cuts a low phase short. The control word is frozen for as long as the clock is active.

Top module: `serclk_gen`

## Requirements
- R1: During and straight after reset, `scl_o` is 1 and both `sda_chg_stb` and `smp_stb` are 0.
- R2: While `run_en` is 0 and `scl_o` is 1 the block is idle: `scl_o` stays 1 and neither strobe pulses.
- R3: After `run_en` goes high from idle, `scl_o` falls after the (D+1)-th rising parent edge at which `run_en` is sampled high. D is the divider, `ctl_word[7:0]`.
- R4: While active, each high and low phase of `scl_o` lasts exactly D+1 parent cycles, so the period is 2 × (D+1). This holds up to D = 255.
- R5: `smp_stb` is a one-cycle pulse in the first parent cycle in which `scl_o` is high after a low phase, and at no other time.
- R6: `sda_chg_stb` is a one-cycle pulse in the cycle that begins N rising parent edges after the edge that drove `scl_o` low. N is the hold field `ctl_word[10:8]`, and the value 0 acts as 1. It may fall in the same cycle as `smp_stb`.
- R7: Each falling edge of `scl_o` restarts the hold count. A hold that ends on the next falling edge still pulses. A longer hold never pulses.
- R8: If `run_en` drops while `scl_o` is low, the low phase still lasts its full D+1 cycles. `scl_o` then rises, with its `smp_stb`, and stays high. A hold count that is still pending when the block goes idle is dropped.
- R9: `ctl_word` is captured only in idle cycles. Changes made while the clock is active have no effect on `scl_o` or on either strobe.
- R10: With D = 0, `scl_o` toggles on every parent cycle while active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run request for the bus clock |
| ctl_word | input | 11 | Clock control: divider in bits 7:0, hold count in bits 10:8 |
| scl_o | output | 1 | Bus clock level, high when idle |
| sda_chg_stb | output | 1 | One-cycle pulse: the data line may now change |
| smp_stb | output | 1 | One-cycle pulse at the clock rising edge: capture read data |

## Verification
Two strobes can land in the same cycle:
- The data-change strobe and the capture strobe coincide when the hold equals D+1. This is provoked with D = 1 and a hold of 2.
- A hold count can expire on the same edge that reloads it. This is provoked with D = 1 and a hold of 4.

In both cases a behavioural model, built on phase ages rather than on the design's counters, judges every cycle. It expects both pulses where they fall, and it expects the reload to take effect without losing the expiring pulse. Stop requests are also swept over every offset within a period, so that a stop landing in a low phase is always covered.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
   // Default field widths of the clock control word.
   localparam int unsigned SCK_DIV_W = 8;   // divider field, LSBs
   localparam int unsigned SCK_DLY_W = 3;   // hold field, above the divider
endpackage

// File: rtl/serclk_halfcnt.sv
module serclk_halfcnt #(
   parameter int unsigned DIV_W = serclk_pkg::SCK_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output logic             scl_q,
   output logic             fall_o,
   output logic             smp_q
);
   logic [DIV_W-1:0] hcnt;
   logic             toggle;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("serclk_halfcnt: DIV_W must be at least 1");
      end
   endgenerate

   assign toggle = active && (hcnt == div);
   assign fall_o = toggle && scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt  <= '0;
         scl_q <= 1'b1;
         smp_q <= 1'b0;
      end else if (!active) begin
         hcnt  <= '0;
         scl_q <= 1'b1;
         smp_q <= 1'b0;
      end else begin
         hcnt  <= toggle ? '0 : hcnt + 1'b1;
         if (toggle) scl_q <= ~scl_q;
         smp_q <= toggle && !scl_q;
      end
   end

   // R4: the level holds between terminal counts
   p_scl_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !toggle) |=> $stable(scl_q));
   // R4: the half-period counter never passes the divider
   p_hcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt <= div);
   // R5: a capture pulse only accompanies a fresh rising level
   p_smp_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      smp_q |-> (scl_q && !$past(scl_q)));
endmodule

// File: rtl/serclk_hold.sv
module serclk_hold #(
   parameter int unsigned DLY_W = serclk_pkg::SCK_DLY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             fall,
   input  logic [DLY_W-1:0] dly,
   output logic             stb_q
);
   logic [DLY_W-1:0] dcnt;
   logic [DLY_W-1:0] dly_eff;

   generate
      if (DLY_W < 1) begin : g_bad_dly
         $error("serclk_hold: DLY_W must be at least 1");
      end
   endgenerate

   assign dly_eff = (dly == '0) ? DLY_W'(1) : dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt  <= '0;
         stb_q <= 1'b0;
      end else if (!active) begin
         dcnt  <= '0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= (dcnt == DLY_W'(1));
         if (fall)            dcnt <= dly_eff;
         else if (dcnt != '0) dcnt <= dcnt - 1'b1;
      end
   end

   // R6: no data strobe follows an idle cycle
   p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !stb_q);
   // R6: a hold of one strobes two edges after the falling-edge decision
   p_hold_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && fall && dly_eff == DLY_W'(1)) ##1 active |=> stb_q);
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
   parameter int unsigned DIV_W = serclk_pkg::SCK_DIV_W,
   parameter int unsigned DLY_W = serclk_pkg::SCK_DLY_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run_en,
   input  logic [DIV_W+DLY_W-1:0] ctl_word,
   output logic                   scl_o,
   output logic                   sda_chg_stb,
   output logic                   smp_stb
);
   localparam int unsigned CTL_W = DIV_W + DLY_W;

   logic [CTL_W-1:0] cfg;
   logic             active;
   logic             scl_q;
   logic             fall;

   // Active while requested, or while a low phase must still finish.
   assign active = run_en || !scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg <= '0;
      else if (!active) cfg <= ctl_word;
   end

   serclk_halfcnt #(.DIV_W(DIV_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .div    (cfg[DIV_W-1:0]),
      .scl_q  (scl_q),
      .fall_o (fall),
      .smp_q  (smp_stb)
   );

   serclk_hold #(.DLY_W(DLY_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .fall   (fall),
      .dly    (cfg[CTL_W-1:DIV_W]),
      .stb_q  (sda_chg_stb)
   );

   assign scl_o = scl_q;

   // R2: an idle clock stays high
   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && scl_o) |=> scl_o);
   // R9: the captured configuration is frozen while active
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(cfg));
   // R8: a low phase is never cut short by a stop request
   p_no_runt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_o) && cfg[DIV_W-1:0] != '0) |=> !scl_o);
endmodule

// File: tb/tb_serclk_gen.sv
`timescale 1ns/1ps
module tb_serclk_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [10:0] ctl_word = '0;
   logic        scl_o, sda_chg_stb, smp_stb;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string phase = "R1";

   // behavioural reference state
   bit m_scl = 1'b1, m_smp = 1'b0, m_sda = 1'b0;
   int m_since = 0, m_age = -1, m_div = 0, m_dly = 0;
   bit m_act, m_tog;
   int m_nd;

   always #2.5 clk = ~clk;

   serclk_gen dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .ctl_word(ctl_word),
      .scl_o(scl_o), .sda_chg_stb(sda_chg_stb), .smp_stb(smp_stb)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_scl = 1; m_smp = 0; m_sda = 0; m_since = 0; m_age = -1;
         m_div = 0; m_dly = 0;
      end else begin
         m_act = run_en || !m_scl;
         if (!m_act) begin
            m_div = int'(ctl_word[7:0]); m_dly = int'(ctl_word[10:8]);
            m_scl = 1; m_smp = 0; m_sda = 0; m_since = 0; m_age = -1;
         end else begin
            m_tog = (m_since == m_div);
            m_nd  = (m_dly == 0) ? 1 : m_dly;
            m_smp = m_tog && !m_scl;
            m_sda = 0;
            if (m_age >= 0) begin
               m_age++;
               if (m_age == m_nd) begin m_sda = 1; m_age = -1; end
            end
            if (m_tog && m_scl) m_age = 0;
            m_since = m_tog ? 0 : m_since + 1;
            if (m_tog) m_scl = !m_scl;
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(phase, "scl_o", int'(scl_o), int'(m_scl));
         chk(phase, "smp_stb", int'(smp_stb), int'(m_smp));
         chk(phase, "sda_chg_stb", int'(sda_chg_stb), int'(m_sda));
      end
   end

   task automatic go(string req, int div, int dly, int cycles);
      run_en = 1'b0;
      @(negedge clk);
      ctl_word = {3'(dly), 8'(div)};
      @(negedge clk);
      phase = req;
      run_en = 1'b1;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic stop_idle(int cycles);
      run_en = 1'b0;
      repeat (cycles) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "scl_o reset", int'(scl_o), 1);
      chk("R1", "smp_stb reset", int'(smp_stb), 0);
      chk("R1", "sda_chg_stb reset", int'(sda_chg_stb), 0);

      // R2: idle stays high
      phase = "R2";
      ctl_word = {3'd2, 8'd3};
      repeat (6) @(negedge clk);

      // R3: first fall after D+1 sampled edges
      phase = "R3";
      run_en = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk("R3", "scl_o before first fall", int'(scl_o), 1);
      end
      @(negedge clk);
      chk("R3", "scl_o first fall", int'(scl_o), 0);

      // R4, R5, R6: steady running
      phase = "R4";
      repeat (40) @(negedge clk);

      // R8: stop while low
      phase = "R8";
      while (scl_o) @(negedge clk);
      stop_idle(14);

      // R6: hold equals half period, strobes coincide
      go("R6", 1, 2, 30);
      go("R5", 2, 1, 30);
      // R7: hold ending on the next fall, and hold never reached
      go("R7", 1, 4, 30);
      go("R7", 0, 5, 20);
      // R9: change control word while active
      go("R9", 2, 1, 8);
      ctl_word = {3'd7, 8'd9};
      repeat (30) @(negedge clk);
      // R10: divider zero, hold zero treated as one
      go("R10", 0, 0, 20);
      // R8: stop at every offset within a period
      for (int off = 0; off < 8; off++) begin
         go("R8", 3, 6, 9 + off);
         stop_idle(12);
      end
      // R4: largest divider and hold
      go("R4", 255, 7, 1100);
      stop_idle(300);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule